// File: doc/BRIEF.md
# Fixed-Prime 192-bit Modular Multiplier

This block multiplies two 192-bit field elements and returns their product modulo the prime p = 2^192 − 2^64 − 1. A single-cycle `start` pulse captures both operands. The block then runs a bit-serial multiply. It does no modular reduction while it multiplies. Each clock it consumes one bit of `y`, most significant bit first, and adds the bit's partial product into a pair of redundant sum and carry vectors, so no carry has to ripple during that phase. After the last bit, a ripple adder joins the two vectors into the exact 384-bit product.

A folding stage then uses the special shape of the prime. It splits the product into six 64-bit words c5..c0, with c0 the least significant. It adds four 192-bit terms: the low half (c2,c1,c0), then (0,c3,c3), then (c4,c4,0), then (c5,c5,c5). The sum is congruent to the product and is smaller than 4p. Exactly three conditional subtractions of p then bring it into [0, p−1].

The controller has six named states: IDLE, MULT, MERGE, FOLD, CORR and DONE. Its transitions are ACCEPT (IDLE or DONE to MULT when `start` is high), LAST_BIT (MULT to MERGE after 192 bit steps), MERGED (MERGE to FOLD), FOLDED (FOLD to CORR), SETTLED (CORR to DONE after three correction steps) and RESET (any state to IDLE). Latency is fixed. `done` rises on the 197th rising edge after the edge that accepted `start`. Operands are assumed to be already below p.

Top module: `p192_modmul`

## Requirements
- R1: A synchronous reset, sampled at a rising edge with `rst` high, returns the block to IDLE from any state, with `done` low and `z` equal to zero.
- R2: When `start` is high at a rising edge while the block is idle or finished, the operands are accepted and `done` is low after that edge.
- R3: For operands x, y < p, the result `z` equals x·y mod p, where p = 2^192 − 2^64 − 1.
- R4: `done` stays low for 196 rising edges after the accepting edge and is high after the 197th.
- R5: While `done` is high and `start` stays low, `z` and `done` hold their values, whatever happens on `x` and `y`.
- R6: A `start` pulse that arrives while an operation is in progress is ignored. The running result and its latency are unchanged.
- R7: The operands are captured at the accepting edge. Later changes on `x` and `y` have no effect on the result.
- R8: The result always lies in [0, p−1], including for edge operands 0, 1, p−1 and 2^191, and for cases such as (p−1)·(p−1) where several correction subtractions are needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins an operation when the block is idle or finished |
| x | input | 192 | Multiplicand, below p |
| y | input | 192 | Multiplier, below p, consumed MSB first |
| z | output | 192 | Reduced product, valid while `done` is high |
| done | output | 1 | High when `z` holds the result of the last accepted operation |

## Verification
A bad bit in the sum/carry pair or in the bit counter is not visible until the operation ends. It then appears as a wrong `z`, or as `done` rising at the wrong edge, 197 cycles after the start. The bench therefore compares every result with an independent modular reference and pins the rising edge of `done` to one exact cycle. A fold or correction fault appears only for some operand shapes, so the bench mixes random operands with cases that drive the folded sum toward its upper bound. A control fault, such as a restart on a busy `start` or a loss of hold, shows within a cycle of the stimulus that caused it.

// File: rtl/p192_pkg.sv
package p192_pkg;
    localparam int WORD_W      = 64;
    localparam int OP_W        = 3 * WORD_W;
    localparam int PROD_W      = 2 * OP_W;
    localparam int ACC_W       = OP_W + 2;
    localparam int CNT_W       = $clog2(OP_W);
    localparam int CORR_STEPS  = 3;
    localparam int CORR_CNT_W  = $clog2(CORR_STEPS + 1);

    // p = 2^192 - 2^64 - 1: all ones except bit WORD_W
    localparam logic [OP_W-1:0] PRIME = {OP_W{1'b1}} ^ (OP_W'(1) << WORD_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MULT,
        ST_MERGE,
        ST_FOLD,
        ST_CORR,
        ST_DONE
    } mm_state_e;
endpackage

// File: rtl/p192_csa_mac.sv
// Carry-save shift-and-add accumulator: acc = 2*acc + bit*mcand, MSB first.
module p192_csa_mac #(
    parameter int OP_W   = 192,
    parameter int PROD_W = 2 * OP_W
) (
    input  logic              clk,
    input  logic              clear,
    input  logic              step,
    input  logic [OP_W-1:0]   mcand,
    input  logic              bit_i,
    output logic [PROD_W-1:0] sum_q,
    output logic [PROD_W-1:0] carry_q
);
    logic [PROD_W-1:0] s_sh, c_sh, addend, s_nx, c_nx;

    always_comb begin
        s_sh   = sum_q << 1;
        c_sh   = carry_q << 1;
        addend = bit_i ? PROD_W'(mcand) : '0;
        s_nx   = s_sh ^ c_sh ^ addend;
        c_nx   = ((s_sh & c_sh) | (s_sh & addend) | (c_sh & addend)) << 1;
    end

    always_ff @(posedge clk) begin
        if (clear) begin
            sum_q   <= '0;
            carry_q <= '0;
        end else if (step) begin
            sum_q   <= s_nx;
            carry_q <= c_nx;
        end
    end
endmodule

// File: rtl/p192_merge_add.sv
// Ripple-carry merge of the redundant pair; carry out is discarded
// because the true product fits in W bits.
module p192_merge_add #(
    parameter int W = 384
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    always_comb begin
        logic cy;
        cy = 1'b0;
        for (int i = 0; i < W; i++) begin
            sum[i] = a[i] ^ b[i] ^ cy;
            cy     = (a[i] & b[i]) | (cy & (a[i] ^ b[i]));
        end
    end
endmodule

// File: rtl/p192_fold.sv
// Folding reduction specialised to 2^(3w) - 2^w - 1.
module p192_fold #(
    parameter int WORD_W = 64
) (
    input  logic [6*WORD_W-1:0] prod,
    output logic [3*WORD_W+1:0] folded
);
    localparam int OP_W  = 3 * WORD_W;
    localparam int OUT_W = OP_W + 2;

    logic [WORD_W-1:0] w [6];
    logic [OUT_W-1:0]  t_low, t_w3, t_w4, t_w5;

    for (genvar g = 0; g < 6; g++) begin : g_split
        assign w[g] = prod[g*WORD_W +: WORD_W];
    end

    always_comb begin
        t_low  = {2'b00, w[2], w[1], w[0]};
        t_w3   = {2'b00, {WORD_W{1'b0}}, w[3], w[3]};
        t_w4   = {2'b00, w[4], w[4], {WORD_W{1'b0}}};
        t_w5   = {2'b00, w[5], w[5], w[5]};
        folded = t_low + t_w3 + t_w4 + t_w5;
    end
endmodule

// File: rtl/p192_modmul.sv
module p192_modmul
    import p192_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [191:0]     x,
    input  logic [191:0]     y,
    output logic [191:0]     z,
    output logic             done
);
    mm_state_e               state_q, state_d;
    logic [CNT_W-1:0]        bit_cnt_q;
    logic [CORR_CNT_W-1:0]   corr_cnt_q;
    logic [OP_W-1:0]         x_q, y_q;
    logic [PROD_W-1:0]       csa_s, csa_c, merged, prod_q;
    logic [ACC_W-1:0]        folded, acc_q, acc_sub;
    logic [OP_W-1:0]         z_q;
    logic                    done_q;
    logic                    accept, last_bit, last_corr;

    localparam logic [ACC_W-1:0] PRIME_EXT = ACC_W'(PRIME);

    assign accept    = start && (state_q == ST_IDLE || state_q == ST_DONE);
    assign last_bit  = (bit_cnt_q == CNT_W'(OP_W - 1));
    assign last_corr = (corr_cnt_q == CORR_CNT_W'(CORR_STEPS - 1));

    p192_csa_mac #(.OP_W(OP_W), .PROD_W(PROD_W)) u_mac (
        .clk     (clk),
        .clear   (accept),
        .step    (state_q == ST_MULT),
        .mcand   (x_q),
        .bit_i   (y_q[OP_W-1]),
        .sum_q   (csa_s),
        .carry_q (csa_c)
    );

    p192_merge_add #(.W(PROD_W)) u_merge (
        .a   (csa_s),
        .b   (csa_c),
        .sum (merged)
    );

    p192_fold #(.WORD_W(WORD_W)) u_fold (
        .prod   (prod_q),
        .folded (folded)
    );

    assign acc_sub = (acc_q >= PRIME_EXT) ? (acc_q - PRIME_EXT) : acc_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)     state_d = ST_MULT;   // ACCEPT
            ST_MULT:  if (last_bit)  state_d = ST_MERGE;  // LAST_BIT
            ST_MERGE:                state_d = ST_FOLD;   // MERGED
            ST_FOLD:                 state_d = ST_CORR;   // FOLDED
            ST_CORR:  if (last_corr) state_d = ST_DONE;   // SETTLED
            ST_DONE:  if (start)     state_d = ST_MULT;   // ACCEPT
            default:                 state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt_q  <= '0;
            corr_cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        x_q       <= x;
                        y_q       <= y;
                        bit_cnt_q <= '0;
                    end
                end
                ST_MULT: begin
                    y_q       <= y_q << 1;
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                end
                ST_MERGE: prod_q <= merged;
                ST_FOLD: begin
                    acc_q      <= folded;
                    corr_cnt_q <= '0;
                end
                ST_CORR: begin
                    acc_q      <= acc_sub;
                    corr_cnt_q <= corr_cnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            z_q    <= '0;
            done_q <= 1'b0;
        end else if (accept) begin
            done_q <= 1'b0;
        end else if (state_q == ST_CORR && last_corr) begin
            z_q    <= acc_sub[OP_W-1:0];
            done_q <= 1'b1;
        end
    end

    assign z    = z_q;
    assign done = done_q;

    a_r2_accept_clears_done: assert property (@(posedge clk) disable iff (rst)
        accept |=> !done);

    a_r4_done_after_corr: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(state_q) == ST_CORR && $past(corr_cnt_q) == CORR_CNT_W'(CORR_STEPS - 1)));

    a_r4_corr_bounded: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CORR) |-> (corr_cnt_q < CORR_CNT_W'(CORR_STEPS)));

    a_r5_result_holds: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(z)));

    a_r6_busy_keeps_counting: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MULT && !last_bit) |=> (state_q == ST_MULT && bit_cnt_q == $past(bit_cnt_q) + 1'b1));

    a_r8_result_below_p: assert property (@(posedge clk) disable iff (rst)
        done |-> (z < PRIME));
endmodule

// File: tb/p192_modmul_tb.sv
module p192_modmul_tb_top;
    localparam logic [191:0] P = 192'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFE_FFFFFFFF_FFFFFFFF;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [191:0] x = '0, y = '0;
    logic [191:0] z;
    logic         done;
    int           n_checks = 0;
    int           n_fail = 0;
    bit           finished = 1'b0;

    always #5 clk = ~clk;

    p192_modmul dut_i (
        .clk(clk), .rst(rst), .start(start),
        .x(x), .y(y), .z(z), .done(done)
    );

    function automatic logic [191:0] ref_mul(logic [191:0] a, logic [191:0] b);
        logic [193:0] r = '0;
        for (int i = 191; i >= 0; i--) begin
            r = r << 1;
            if (r >= {2'b00, P}) r = r - {2'b00, P};
            if (b[i]) begin
                r = r + {2'b00, a};
                if (r >= {2'b00, P}) r = r - {2'b00, P};
            end
        end
        return r[191:0];
    endfunction

    function automatic logic [191:0] rand_elem();
        logic [191:0] v = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        if (v >= P) v = v - P;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [191:0] act, input logic [191:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // One operation with latency checks; disturb injects busy start and operand changes.
    task automatic run_op(input logic [191:0] a, input logic [191:0] b, input bit disturb, input string req);
        logic [191:0] exp = ref_mul(a, b);
        bit early = 1'b0;
        @(negedge clk); x = a; y = b; start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(done == 1'b0, "R2 done low after accept", {191'd0, done}, 192'd0);
        for (int k = 1; k < 197; k++) begin
            @(negedge clk);
            if (done) early = 1'b1;
            if (disturb && k == 50) begin x = rand_elem(); y = rand_elem(); start = 1'b1; end
            if (disturb && k == 51) start = 1'b0;
            if (disturb && k == 100) begin x = rand_elem(); y = rand_elem(); end
        end
        check(!early, "R4 done low for 196 edges", {191'd0, early}, 192'd0);
        @(negedge clk);
        check(done == 1'b1, "R4 done high at edge 197", {191'd0, done}, 192'd1);
        check(z == exp, req, z, exp);
    endtask

    task automatic hold_check();
        logic [191:0] z0 = z;
        bit ok = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); x = rand_elem(); y = rand_elem();
            if (z != z0 || !done) ok = 1'b0;
        end
        check(ok, "R5 z and done hold", z, z0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R4 watchdog expired: actual hung expected finished");
        summary();
    end

    initial begin
        logic [191:0] two191 = 192'd1 << 191;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0 && z == '0, "R1 reset state", z, 192'd0);

        run_op(P - 1, P - 1, 1'b0, "R8 (p-1)^2");
        run_op('0, rand_elem(), 1'b0, "R8 zero operand");
        run_op(192'd1, P - 1, 1'b0, "R8 one times p-1");
        run_op(two191, two191, 1'b0, "R8 2^191 squared");
        run_op(P - 1, two191, 1'b0, "R8 p-1 times 2^191");
        hold_check();
        run_op(rand_elem(), rand_elem(), 1'b1, "R6 R7 busy start and operand change ignored");
        hold_check();

        // R1: reset in the middle of an operation
        @(negedge clk); x = rand_elem(); y = rand_elem(); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(done == 1'b0 && z == '0, "R1 reset mid-operation", z, 192'd0);
        repeat (5) @(negedge clk);
        check(done == 1'b0, "R1 stays idle after reset", {191'd0, done}, 192'd0);

        for (int n = 0; n < 20; n++) begin
            run_op(rand_elem(), rand_elem(), n % 5 == 4, "R3 random product");
        end
        run_op(P - 1, P - 2, 1'b0, "R3 near-modulus operands");
        hold_check();
        summary();
    end
endmodule